// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the two upstream USB data lines and decides when the host has signalled a bus reset. A bus reset is a single-ended-zero (SE0) state, with both lines low, held long enough. The lines are first brought into the 12 MHz clock domain by a multi-stage synchroniser. A counter then measures how long the SE0 state has lasted without a break. The acceptance window runs from 12 µs to 16 µs: an SE0 longer than 16 µs must be taken as a reset, and one as short as 12 µs may be. The default threshold is 168 clocks (14 µs), which sits inside that window. Any break in the SE0 state before the threshold sets the count back to zero and leaves no trace.

When a reset is recognised, the block does three things in the same cycle. It sets a sticky status flag, which stays set until the CPU clears it. It sends a one-cycle strobe that wipes the device address register. If the power-on start-up delay is still running, it also sends a one-cycle strobe that aborts that delay. The interrupt is not raised at recognition. It is a one-cycle pulse, sent when the lines leave SE0 at the end of the reset.

Top module: `busreset_watch`

## Requirements
- R1: The line pair is decoded as {D+, D−}. Only 2'b00 is SE0. The states 2'b01, 2'b10 and 2'b11 never count toward a reset, however long they are held.
- R2: Let N be the number of clock edges at which the raw inputs are in SE0 without a break, and let E be the first of those edges. The block recognises a reset if and only if N ≥ THRESH_CLKS. The recognition strobes rise after edge E + SYNC_STAGES − 1 + THRESH_CLKS.
- R3: An SE0 run shorter than THRESH_CLKS has no effect on any output. A single non-SE0 sample between two short runs starts the count again from zero.
- R4: The status flag is set on recognition and stays set until the CPU's clear input is sampled high. When a recognition and a clear fall on the same edge, the recognition wins.
- R5: The address-wipe strobe is high for exactly one cycle per recognised reset, in the same cycle that the status flag is set.
- R6: The start-up-abort strobe is high for one cycle, together with the address-wipe strobe, only if the start-up-delay flag is high at the recognising edge. Otherwise it stays low.
- R7: The interrupt is a one-cycle pulse at the end of a recognised reset. It rises after edge E + SYNC_STAGES + N, which is one edge after the synchronised lines leave SE0. An SE0 run that was not recognised gives no interrupt.
- R8: An SE0 held far beyond the threshold gives exactly one address-wipe strobe and one interrupt.
- R9: Under reset, the status flag, the interrupt, the address-wipe strobe and the start-up-abort strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_p_i | input | 1 | Raw D+ level |
| line_n_i | input | 1 | Raw D− level |
| stat_clr_i | input | 1 | CPU request to clear the status flag |
| boot_wait_i | input | 1 | High while the power-on start-up delay is running |
| stat_o | output | 1 | Sticky flag: a bus reset was recognised |
| irq_o | output | 1 | One-cycle interrupt at SE0 release |
| addr_wipe_o | output | 1 | One-cycle strobe that clears the device address |
| boot_abort_o | output | 1 | One-cycle strobe that aborts the start-up delay |

## Verification
The assertions watch, on every cycle, the relations between the outputs:
- each strobe lasts one cycle;
- the address-wipe strobe coincides with a set status flag;
- the abort strobe only ever rides on an address-wipe strobe;
- the interrupt never shares a cycle with recognition;
- the status flag holds without a clear;
- the SE0 counter saturates.

Only the bench's scenarios can show the timing. A sweep over every SE0 length up to more than twice the threshold checks the exact recognition edge and the exact release edge. It also confirms that no run shorter than the threshold is recognised. Further scenarios show that non-SE0 states and split short runs are ignored, and that a clear on the recognising edge loses to the recognition.

// File: rtl/busreset_pkg.sv
package busreset_pkg;

   // Line pair encoded as {D+, D-}
   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_K   = 2'b01,
      LS_J   = 2'b10,
      LS_SE1 = 2'b11
   } line_state_e;

   // Level of the line pair while the bus is idle
   localparam logic [1:0] LINE_IDLE = LS_J;

   function automatic logic is_se0(input logic [1:0] pn);
      return (line_state_e'(pn) == LS_SE0);
   endfunction

endpackage

// File: rtl/busreset_sync.sv
module busreset_sync #(
   parameter int unsigned WIDTH   = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("busreset_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("busreset_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < int'(STAGES); i++) chain_q[i] <= RST_VAL;
      end else begin
         chain_q[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/busreset_se0_timer.sv
module busreset_se0_timer #(
   parameter int unsigned THRESH = 168
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic se0_i,
   output logic hit_o
);

   localparam int unsigned CW = $clog2(THRESH + 1);
   localparam logic [CW-1:0] LIMIT = CW'(THRESH);
   localparam logic [CW-1:0] LAST  = CW'(THRESH - 1);

   if (THRESH < 2) begin : g_bad_thresh
      $error("busreset_se0_timer: THRESH must be at least 2");
   end

   logic [CW-1:0] run_q;

   // The count starts again on any break and holds at LIMIT
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               run_q <= '0;
      else if (!se0_i)           run_q <= '0;
      else if (run_q != LIMIT)   run_q <= run_q + 1'b1;
   end

   // Only the step into LIMIT counts as a hit
   assign hit_o = se0_i && (run_q == LAST);

   a_r8_run_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= LIMIT);

   a_r2_hit_reaches_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |=> (run_q == LIMIT));

endmodule

// File: rtl/busreset_event.sv
module busreset_event (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic se0_i,
   input  logic hit_i,
   input  logic clr_i,
   input  logic boot_wait_i,
   output logic stat_o,
   output logic irq_o,
   output logic wipe_o,
   output logic abort_o
);

   logic stat_q, irq_q, wipe_q, abort_q, armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_q  <= 1'b0;
         irq_q   <= 1'b0;
         wipe_q  <= 1'b0;
         abort_q <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         // A recognition on the same edge beats a clear
         stat_q  <= hit_i | (stat_q & ~clr_i);
         wipe_q  <= hit_i;
         abort_q <= hit_i & boot_wait_i;
         irq_q   <= armed_q & ~se0_i;
         if (hit_i)                armed_q <= 1'b1;
         else if (!se0_i)          armed_q <= 1'b0;
      end
   end

   assign stat_o  = stat_q;
   assign irq_o   = irq_q;
   assign wipe_o  = wipe_q;
   assign abort_o = abort_q;

   a_r4_stat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q && !clr_i) |=> stat_q);

   a_r7_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |=> !irq_q);

   a_r5_wipe_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wipe_q |=> !wipe_q);

endmodule

// File: rtl/busreset_watch.sv
module busreset_watch #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned THRESH_CLKS  = 168,
   parameter int unsigned WIN_MIN_CLKS = 144,
   parameter int unsigned WIN_MAX_CLKS = 192,
   parameter bit          CHECK_WINDOW = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_p_i,
   input  logic line_n_i,
   input  logic stat_clr_i,
   input  logic boot_wait_i,
   output logic stat_o,
   output logic irq_o,
   output logic addr_wipe_o,
   output logic boot_abort_o
);
   import busreset_pkg::*;

   if (CHECK_WINDOW) begin : g_window
      if (THRESH_CLKS < WIN_MIN_CLKS || THRESH_CLKS > WIN_MAX_CLKS) begin : g_bad
         $error("busreset_watch: THRESH_CLKS lies outside the acceptance window");
      end
   end

   logic [1:0] line_s;
   logic       se0;
   logic       hit;

   busreset_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES),
      .RST_VAL(LINE_IDLE)
   ) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({line_p_i, line_n_i}),
      .q_o   (line_s)
   );

   assign se0 = is_se0(line_s);

   busreset_se0_timer #(
      .THRESH(THRESH_CLKS)
   ) i_timer (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .se0_i (se0),
      .hit_o (hit)
   );

   busreset_event i_event (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .se0_i      (se0),
      .hit_i      (hit),
      .clr_i      (stat_clr_i),
      .boot_wait_i(boot_wait_i),
      .stat_o     (stat_o),
      .irq_o      (irq_o),
      .wipe_o     (addr_wipe_o),
      .abort_o    (boot_abort_o)
   );

   a_r5_wipe_sets_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_wipe_o |-> stat_o);

   a_r6_abort_rides_wipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      boot_abort_o |-> addr_wipe_o);

   a_r7_irq_apart_from_wipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> !addr_wipe_o);

endmodule

// File: tb/test_busreset_watch.sv
module test_busreset_watch;

   localparam int T = 10;
   localparam int S = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lp = 1'b1, ln = 1'b0, clr = 1'b0, boot = 1'b0;
   logic stat, irq, wipe, abort_s;

   int cyc = 0;
   int errors = 0, checks = 0;
   int wipe_cnt, wipe_cyc, irq_cnt, irq_cyc, abort_cnt;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   busreset_watch #(
      .SYNC_STAGES (S),
      .THRESH_CLKS (T),
      .CHECK_WINDOW(1'b0)
   ) i_busreset_watch (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .line_p_i    (lp),
      .line_n_i    (ln),
      .stat_clr_i  (clr),
      .boot_wait_i (boot),
      .stat_o      (stat),
      .irq_o       (irq),
      .addr_wipe_o (wipe),
      .boot_abort_o(abort_s)
   );

   // Watch the strobes away from the active edge
   always @(negedge clk) begin
      if (wipe)    begin wipe_cnt++; wipe_cyc = cyc; end
      if (irq)     begin irq_cnt++;  irq_cyc  = cyc; end
      if (abort_s) abort_cnt++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      wipe_cnt = 0; wipe_cyc = -1; irq_cnt = 0; irq_cyc = -1; abort_cnt = 0;
   endtask

   task automatic clear_stat();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      @(negedge clk);
      check(stat == 1'b0, "R4 clear", int'(stat), 0);
   endtask

   // Hold a line state for n raw edges, then return to idle
   task automatic hold_state(input logic p, input logic n, input int len, output int e0);
      @(negedge clk);
      lp = p; ln = n;
      e0 = cyc + 1;
      repeat (len) @(negedge clk);
      lp = 1'b1; ln = 1'b0;
   endtask

   task automatic quiet_check(input string req);
      check(wipe_cnt == 0, req, wipe_cnt, 0);
      check(irq_cnt == 0, req, irq_cnt, 0);
      check(stat == 1'b0, req, int'(stat), 0);
   endtask

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int e0;
      clear_counts();
      repeat (3) @(negedge clk);
      // R9: outputs low under reset
      check({stat, irq, wipe, abort_s} == 4'b0, "R9 reset", int'({stat, irq, wipe, abort_s}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check({stat, irq, wipe, abort_s} == 4'b0, "R9 after reset", int'({stat, irq, wipe, abort_s}), 0);

      // R2 R3 R5 R6 R7 R8: sweep of every SE0 length
      for (int n = 1; n <= 2 * T + 3; n++) begin
         clear_stat();
         clear_counts();
         boot = n[0];
         hold_state(1'b0, 1'b0, n, e0);
         repeat (T + 8) @(negedge clk);
         boot = 1'b0;
         if (n >= T) begin
            check(wipe_cnt == 1, "R5 wipe count", wipe_cnt, 1);
            check(wipe_cyc == e0 + S - 1 + T, "R2 recognition edge", wipe_cyc, e0 + S - 1 + T);
            check(irq_cnt == 1, "R8 irq count", irq_cnt, 1);
            check(irq_cyc == e0 + S + n, "R7 release edge", irq_cyc, e0 + S + n);
            check(abort_cnt == n % 2, "R6 abort", abort_cnt, n % 2);
            check(stat == 1'b1, "R4 sticky", int'(stat), 1);
         end else begin
            quiet_check("R3 short run");
            check(abort_cnt == 0, "R3 short abort", abort_cnt, 0);
         end
      end

      // R1: K, SE1 and J held long are not resets
      clear_stat();
      clear_counts();
      hold_state(1'b0, 1'b1, 3 * T, e0);
      repeat (T) @(negedge clk);
      quiet_check("R1 K state");
      hold_state(1'b1, 1'b1, 3 * T, e0);
      repeat (T) @(negedge clk);
      quiet_check("R1 SE1 state");
      hold_state(1'b1, 1'b0, 3 * T, e0);
      repeat (T) @(negedge clk);
      quiet_check("R1 J state");

      // R3: two short runs split by one idle sample
      clear_counts();
      hold_state(1'b0, 1'b0, T - 1, e0);
      @(negedge clk);
      lp = 1'b0; ln = 1'b0;
      repeat (T - 1) @(negedge clk);
      lp = 1'b1; ln = 1'b0;
      repeat (T + 6) @(negedge clk);
      quiet_check("R3 split runs");

      // R4: clear on the recognising edge loses
      clear_counts();
      @(negedge clk);
      lp = 1'b0; ln = 1'b0;
      e0 = cyc + 1;
      while (cyc < e0 + S - 2 + T) @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      check(stat == 1'b1, "R4 set wins", int'(stat), 1);
      repeat (T) @(negedge clk);
      lp = 1'b1; ln = 1'b0;
      repeat (6) @(negedge clk);
      check(stat == 1'b1, "R4 held", int'(stat), 1);
      check(wipe_cnt == 1, "R5 single wipe", wipe_cnt, 1);
      check(abort_cnt == 0, "R6 no abort", abort_cnt, 0);
      clear_stat();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule